// File: doc/BRIEF.md
# Quadrature Encoder Timer Channel

This block is a single 16-bit timer channel that counts two-phase encoder pulses. The two phase inputs, A and B, are brought into the clock domain through a synchronizer. Every edge on either input is then decoded into a single step, so the channel counts four times per encoder cycle. When A leads B the count goes up, and when B leads A it goes down. The direction of the last step is kept in a readable bit. A wrap in either direction sets its own sticky flag: overflow when counting up, underflow when counting down.

One compare/capture register sits beside the counter. A step taken while the counter equals this register sets a match flag, and it can optionally send the counter back to zero. A rising edge on a separate capture input can copy the live count into the same register. Software reaches the channel through a small word-wide register port, with writes taking effect at once and reads returned one cycle later. The interrupt line is the registered OR of the flags that are enabled.

Counting happens only when the mode field selects phase counting and the run bit is set. The prescaler and edge-select fields of the control word are stored, but they have no effect in this mode.

Top module: `qdec_timer`

## Requirements
- R1: With {A,B} visiting 00, 10, 11, 01 in that cyclic order (A leading), each single-input change adds 1 to COUNT (address 1). The new value is readable no later than four cycles after the input change.
- R2: With {A,B} visiting 00, 01, 11, 10 in that cyclic order (B leading), each single-input change subtracts 1 from COUNT.
- R3: An up step from 0xFFFF gives 0x0000 and sets overflow flag STATUS (address 3) bit 0. The flag stays set until it is cleared by software.
- R4: A down step from 0x0000 gives 0xFFFF and sets underflow flag STATUS bit 1. The flag stays set until it is cleared by software.
- R5: STATUS bit 4 is 1 after an up step and 0 after a down step. It is 0 out of reset.
- R6: A sample in which A and B both change is an illegal transition. It leaves COUNT and STATUS bit 4 unchanged.
- R7: Counting happens only when CONTROL (address 0) bit 0 (run) is 1 and bits [3:1] (mode) equal 4. The prescaler field [6:4] and the edge field [8:7] have no effect on counting.
- R8: A step taken while COUNT equals CMP (address 2) sets match flag STATUS bit 2. If CONTROL bits [10:9] equal 01, that step loads 0 instead of stepping. This applies in both directions, and such a step sets no wrap flag.
- R9: When CONTROL bit 11 is 1, a rising edge on cap_in copies COUNT into CMP and sets capture flag STATUS bit 3. When bit 11 is 0, a rising edge on cap_in changes neither CMP nor the flag.
- R10: Writing STATUS clears each flag in bits [3:0] whose data bit is 1 and leaves the others unchanged. Writing COUNT loads the counter directly.
- R11: irq is the registered OR over the four flags, each ANDed with the matching bit of IEN (address 4) bits [3:0].
- R12: After reset, every register reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| cap_in | input | 1 | Capture trigger, asynchronous, rising edge active |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Read data, one cycle after rd_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps the counter through both wraps, one step at a time, in each direction. A design with a swapped direction decode, an off-by-one wrap test, or a flag that is not sticky shows a wrong count or a wrong flag at the exact step where the error first appears. Double-input jumps are placed between legal steps, so a design that treats them as a step in either direction drifts away from the arithmetic model. Clear-on-compare is exercised both counting up and counting down, capture is exercised with its enable on and off, and the interrupt mask is tried one bit at a time. These catch a clear that fires one step late, a capture that ignores its enable, and an interrupt that ignores its mask.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  localparam int ADR_W = 3;
  localparam logic [ADR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADR_W-1:0] ADR_COUNT = 3'd1;
  localparam logic [ADR_W-1:0] ADR_CMP   = 3'd2;
  localparam logic [ADR_W-1:0] ADR_STAT  = 3'd3;
  localparam logic [ADR_W-1:0] ADR_IEN   = 3'd4;

  localparam logic [2:0] MODE_PHASE = 3'd4;

  localparam int NFLAG   = 4;
  localparam int FLG_OVF = 0;
  localparam int FLG_UNF = 1;
  localparam int FLG_MAT = 2;
  localparam int FLG_CAP = 3;

  // bit 0 run, [3:1] mode, [6:4] prescaler, [8:7] edge, [10:9] clear source, [11] capture enable
  typedef struct packed {
    logic       cap_en;
    logic [1:0] clr_sel;
    logic [1:0] edge_sel;
    logic [2:0] psc;
    logic [2:0] mode;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/qdec_phase.sv
module qdec_phase
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ab,
  output step_e      step
);

  logic [1:0] prev;

  // position on the cycle 00 -> 10 -> 11 -> 01, with ab = {A,B}
  function automatic logic [1:0] pos(input logic [1:0] v);
    return {v[0], v[1] ^ v[0]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= ab;
  end

  logic [1:0] delta;
  always_comb begin
    delta = pos(ab) - pos(prev);
    case (delta)
      2'd1:    step = STEP_UP;
      2'd3:    step = STEP_DN;
      2'd2:    step = STEP_BAD;
      default: step = STEP_NONE;
    endcase
  end

endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
  import qdec_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  step_e        step,
  input  logic         clr_on,
  input  logic [W-1:0] cmp,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cnt,
  output logic         dir,
  output logic         ovf_p,
  output logic         unf_p,
  output logic         mat_p
);

  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic up, mov, at_cmp, wipe;

  always_comb begin
    up     = (step == STEP_UP);
    mov    = en && (up || step == STEP_DN);
    at_cmp = (cnt == cmp);
    wipe   = mov && clr_on && at_cmp;
    ovf_p  = mov && !wr && !wipe && up && (cnt == TOP);
    unf_p  = mov && !wr && !wipe && !up && (cnt == '0);
    mat_p  = mov && !wr && at_cmp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      dir <= 1'b0;
    end else begin
      if (mov) dir <= up;
      if (wr)        cnt <= wr_val;
      else if (wipe) cnt <= '0;
      else if (mov)  cnt <= up ? cnt + ONE : cnt - ONE;
    end
  end

endmodule

// File: rtl/qdec_regs.sv
module qdec_regs
  import qdec_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic [ADR_W-1:0] rd_addr,
  input  logic [W-1:0]     cnt,
  input  logic             dir,
  input  logic             ovf_p,
  input  logic             unf_p,
  input  logic             mat_p,
  input  logic             cap_p,
  output ctrl_t            ctrl,
  output logic [W-1:0]     cmp,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] ien,
  output logic [W-1:0]     rd_data,
  output logic             irq
);

  logic             cap_hit;
  logic [NFLAG-1:0] set_v, clr_v;

  always_comb begin
    cap_hit        = cap_p && ctrl.cap_en;
    set_v          = '0;
    set_v[FLG_OVF] = ovf_p;
    set_v[FLG_UNF] = unf_p;
    set_v[FLG_MAT] = mat_p;
    set_v[FLG_CAP] = cap_hit;
    clr_v = (wr_en && wr_addr == ADR_STAT) ? wr_data[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      cmp     <= '0;
      flags   <= '0;
      ien     <= '0;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_en && wr_addr == ADR_CTRL) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_en && wr_addr == ADR_IEN)  ien  <= wr_data[NFLAG-1:0];
      if (wr_en && wr_addr == ADR_CMP)  cmp  <= wr_data;
      else if (cap_hit)                 cmp  <= cnt;
      flags <= (flags & ~clr_v) | set_v;
      irq   <= |(flags & ien);
      case (rd_addr)
        ADR_CTRL:  rd_data <= W'(ctrl);
        ADR_COUNT: rd_data <= cnt;
        ADR_CMP:   rd_data <= cmp;
        ADR_STAT:  rd_data <= W'({dir, flags});
        ADR_IEN:   rd_data <= W'(ien);
        default:   rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/qdec_timer.sv
module qdec_timer
  import qdec_pkg::*;
#(
  parameter int CNT_W       = 16,  // must be at least CTRL_W
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             cap_in,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [ADR_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);

  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in, synced;
  assign raw_in = {cap_in, phase_a, phase_b};

  qdec_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(synced)
  );

  step_e step;
  qdec_phase u_phase (
    .clk(clk), .rst(rst), .ab(synced[1:0]), .step(step)
  );

  logic cap_prev, cap_p;
  always_ff @(posedge clk) begin
    if (rst) cap_prev <= 1'b0;
    else     cap_prev <= synced[2];
  end
  assign cap_p = synced[2] & ~cap_prev;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic [NFLAG-1:0] flags_q, ien_q;
  logic             dir_q, ovf_p, unf_p, mat_p;
  logic             cnt_en, clr_on, cnt_wr;

  assign cnt_en = ctrl_q.run && (ctrl_q.mode == MODE_PHASE);
  assign clr_on = (ctrl_q.clr_sel == 2'b01);
  assign cnt_wr = wr_en && (wr_addr == ADR_COUNT);

  qdec_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .step(step), .clr_on(clr_on),
    .cmp(cmp_q), .wr(cnt_wr), .wr_val(wr_data), .cnt(cnt_q), .dir(dir_q),
    .ovf_p(ovf_p), .unf_p(unf_p), .mat_p(mat_p)
  );

  qdec_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cnt(cnt_q), .dir(dir_q), .ovf_p(ovf_p), .unf_p(unf_p),
    .mat_p(mat_p), .cap_p(cap_p), .ctrl(ctrl_q), .cmp(cmp_q), .flags(flags_q),
    .ien(ien_q), .rd_data(rd_data), .irq(irq)
  );

endmodule

// File: rtl/qdec_timer_chk.sv
module qdec_timer_chk
  import qdec_pkg::*;
#(
  parameter int W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     cnt,
  input logic [W-1:0]     cmp,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] ien,
  input logic             irq,
  input logic             dir,
  input step_e            step,
  input logic             cnt_en,
  input logic             cnt_wr,
  input logic             clr_on,
  input logic             wr_en,
  input logic [ADR_W-1:0] wr_addr,
  input logic [W-1:0]     wr_data
);

  logic at_cmp, stat_wr;
  assign at_cmp  = (cnt == cmp);
  assign stat_wr = wr_en && (wr_addr == ADR_STAT);

  assert_step_up_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_en && step == STEP_UP && !cnt_wr && !(clr_on && at_cmp)
      |=> (cnt - $past(cnt)) == W'(1));

  assert_step_dn_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_en && step == STEP_DN && !cnt_wr && !(clr_on && at_cmp)
      |=> ($past(cnt) - cnt) == W'(1));

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_en && step == STEP_UP && !cnt_wr && cnt == '1 && !(clr_on && at_cmp)
      |=> flags[FLG_OVF]);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    flags[FLG_OVF] && !(stat_wr && wr_data[FLG_OVF]) |=> flags[FLG_OVF]);

  assert_unf_set_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_en && step == STEP_DN && !cnt_wr && cnt == '0 && !(clr_on && at_cmp)
      |=> flags[FLG_UNF]);

  assert_dir_up_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_en && step == STEP_UP |=> dir);

  assert_dir_dn_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_en && step == STEP_DN |=> !dir);

  assert_bad_hold_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_en && step == STEP_BAD && !cnt_wr |=> $stable(cnt) && $stable(dir));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !cnt_en && !cnt_wr |=> $stable(cnt) && $stable(dir));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_en && (step == STEP_UP || step == STEP_DN) && !cnt_wr && clr_on && at_cmp
      |=> cnt == '0 && flags[FLG_MAT]);

  assert_irq_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(flags & ien)));

endmodule

bind qdec_timer qdec_timer_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt_q), .cmp(cmp_q), .flags(flags_q), .ien(ien_q),
  .irq(irq), .dir(dir_q), .step(step), .cnt_en(cnt_en), .cnt_wr(cnt_wr),
  .clr_on(clr_on), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/qdec_timer_test.sv
`timescale 1ns/1ps
module qdec_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phase_a = 1'b0, phase_b = 1'b0, cap_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int idx = 0;
  int ecnt = 0;

  always #10 clk = ~clk;

  qdec_timer uut (
    .clk(clk), .rst(rst), .phase_a(phase_a), .phase_b(phase_b), .cap_in(cap_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  // {A,B} per cyclic position: 00, 10, 11, 01
  task automatic move(input int d);
    idx = (idx + d) & 3;
    @(negedge clk);
    case (idx)
      0: {phase_a, phase_b} = 2'b00;
      1: {phase_a, phase_b} = 2'b10;
      2: {phase_a, phase_b} = 2'b11;
      default: {phase_a, phase_b} = 2'b01;
    endcase
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_cap();
    @(negedge clk); cap_in = 1'b1;
    repeat (6) @(negedge clk); cap_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  localparam logic [15:0] CTRL_ON = 16'h01F9; // run, mode 4, prescaler 7, edge 3

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int ovf_e, unf_e;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R12: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); check("R12 reg", v, 0);
    end
    check("R12 irq", int'(irq), 0);

    // R7: no counting with run clear or wrong mode
    wr(3'd0, 16'h0008);
    move(1); rd(3'd1, v); check("R7 run off", v, 0);
    wr(3'd0, 16'h0005);
    move(1); rd(3'd1, v); check("R7 mode", v, 0);
    wr(3'd0, CTRL_ON);
    move(1); ecnt = 1; rd(3'd1, v); check("R7 junk psc/edge", v, ecnt);

    // R1 / R5: up sweep
    for (int i = 0; i < 40; i++) begin
      move(1); ecnt = (ecnt + 1) & 16'hFFFF;
      rd(3'd1, v); check("R1 up", v, ecnt);
      rd(3'd3, v); check("R5 dir up", (v >> 4) & 1, 1);
    end

    // R2 / R4 / R5: down sweep through zero
    unf_e = 0;
    for (int i = 0; i < 60; i++) begin
      if (ecnt == 0) unf_e = 1;
      move(-1); ecnt = (ecnt - 1) & 16'hFFFF;
      rd(3'd1, v); check("R2 down", v, ecnt);
      rd(3'd3, v);
      check("R4 unf", (v >> 1) & 1, unf_e);
      check("R5 dir down", (v >> 4) & 1, 0);
    end

    // R6: illegal double change
    move(2); rd(3'd1, v); check("R6 hold count", v, ecnt);
    rd(3'd3, v); check("R6 hold dir", (v >> 4) & 1, 0);
    move(1); ecnt = (ecnt + 1) & 16'hFFFF;
    rd(3'd1, v); check("R1 after bad", v, ecnt);
    move(2); rd(3'd1, v); check("R6 hold count 2", v, ecnt);
    rd(3'd3, v); check("R6 hold dir 2", (v >> 4) & 1, 1);

    // R3: overflow through wrap
    wr(3'd1, 16'hFFFC); ecnt = 16'hFFFC; ovf_e = 0;
    for (int i = 0; i < 8; i++) begin
      if (ecnt == 16'hFFFF) ovf_e = 1;
      move(1); ecnt = (ecnt + 1) & 16'hFFFF;
      rd(3'd1, v); check("R3 count", v, ecnt);
      rd(3'd3, v); check("R3 ovf", v & 1, ovf_e);
    end
    rd(3'd3, v); check("R3 R4 sticky", v & 16'h13, 16'h13);

    // R10: write-one-to-clear
    wr(3'd3, 16'h0001); rd(3'd3, v); check("R10 clr ovf", v & 16'h13, 16'h12);
    wr(3'd3, 16'h0002); rd(3'd3, v); check("R10 clr unf", v & 16'h13, 16'h10);

    // R8: compare match without clear
    wr(3'd2, 16'd5); wr(3'd1, 16'd3); wr(3'd3, 16'h000F);
    move(1); move(1); rd(3'd1, v); check("R8 reach", v, 5);
    rd(3'd3, v); check("R8 no early match", (v >> 2) & 1, 0);
    move(1); rd(3'd1, v); check("R8 pass", v, 6);
    rd(3'd3, v); check("R8 match", (v >> 2) & 1, 1);

    // R8: clear on compare, up and down
    wr(3'd0, CTRL_ON | 16'h0200); wr(3'd3, 16'h000F); wr(3'd1, 16'd3);
    move(1); move(1); move(1);
    rd(3'd1, v); check("R8 clear up", v, 0);
    rd(3'd3, v); check("R8 clear up flags", v & 16'h7, 16'h4);
    wr(3'd3, 16'h000F); wr(3'd1, 16'd6);
    move(-1); move(-1);
    rd(3'd1, v); check("R8 clear down", v, 0);
    rd(3'd3, v); check("R8 clear down flags", v & 16'h7, 16'h4);

    // R9: capture enabled then disabled
    wr(3'd0, CTRL_ON | 16'h0800); wr(3'd3, 16'h000F); wr(3'd1, 16'h1234);
    pulse_cap();
    rd(3'd2, v); check("R9 capture value", v, 16'h1234);
    rd(3'd3, v); check("R9 capture flag", (v >> 3) & 1, 1);
    wr(3'd0, CTRL_ON); wr(3'd3, 16'h0008); wr(3'd1, 16'h2222);
    pulse_cap();
    rd(3'd2, v); check("R9 capture off value", v, 16'h1234);
    rd(3'd3, v); check("R9 capture off flag", (v >> 3) & 1, 0);

    // R11: interrupt masking
    wr(3'd3, 16'h000F); wr(3'd1, 16'hFFFF);
    move(1); repeat (3) @(negedge clk);
    check("R11 masked", int'(irq), 0);
    wr(3'd4, 16'h0001); repeat (3) @(negedge clk);
    check("R11 ovf enabled", int'(irq), 1);
    wr(3'd4, 16'h0002); repeat (3) @(negedge clk);
    check("R11 other enable", int'(irq), 0);
    wr(3'd4, 16'h0001); repeat (3) @(negedge clk);
    check("R11 re-enable", int'(irq), 1);
    wr(3'd3, 16'h0001); repeat (3) @(negedge clk);
    check("R11 R10 cleared", int'(irq), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule